// File: doc/BRIEF.md
# Spindle Start-up and Brake Controller

This block sequences a sensorless three-phase spindle motor from rest to commutation and back to a stop. A host raises a start control. The controller first runs a short inductive-sense step to find the rotor phase. It then energises the windings for a programmed time and waits for back-EMF zero-crossing pulses from an external comparator. Each pulse advances a six-step commutation counter. If the pulses stop arriving within a programmed window, the controller flags a stuck rotor and brakes.

When start is cleared, the controller applies an optional timed reverse brake and then holds a normal brake. In external mode the host steps the commutation counter directly and can request a sense step on demand. A coast control, or an active power-on reset, disables the power outputs whatever the state. All timing runs from a 1 ms enable pulse, so every programmed duration is an exact number of ticks.

Top module: `spindle_startup`

## Requirements
- R1: During and after reset the controller is in normal brake: brakeOn=1, phaseStep=0, stuckRotor=0, phaseReady=0. From any active state, startBit=0 leaves that state at the next clock and clears phaseStep to 0.
- R2: A 0-to-1 change of startBit while braking, with extMode=0, starts a sense step lasting SENSE_MS ticks (default 2). An energise step follows, lasting (energSel+1)*10 ticks: code 0 gives 10, 1 gives 20, 2 gives 30, 3 gives 40.
- R3: With stopAfterSense=1, the controller sets phaseReady=1 at the end of the sense step and then holds with sense, energise, commutation and brake outputs all low until startBit returns to 0.
- R4: With extMode=1, a start enters external commutation at the next clock with phaseStep=0. Each rising edge of incBit advances phaseStep by one, and bemfPulse is ignored. A rising edge of senseBit runs a sense step and then returns to external commutation. If both rise in the same cycle, the sense step is taken and the step does not advance.
- R5: After energising, if no bemfPulse arrives within 400 ticks (stuckSel=0) or 100 ticks (stuckSel=1), stuckRotor becomes 1 and the controller enters normal brake directly, with no reverse brake. stuckRotor and phaseReady clear at the next start.
- R6: While waiting or running, each bemfPulse advances phaseStep through 0,1,2,3,4,5,0, sets spinning=1 and restarts the full stuck-rotor window.
- R7: On stop, revSel=1, 2 or 3 holds reverse brake for 10, 20 or 40 ticks and then normal brake; revSel=0 goes straight to normal brake. startBit is ignored during reverse brake, but a 0-to-1 change made during it starts the motor one clock after normal brake is reached.
- R8: driveEn is 0 whenever coastBit=1 or rstN=0, and 1 otherwise. The state outputs are not affected.
- R9: A bemfPulse in the same cycle as the tick that closes the stuck-rotor window counts as rotation: stuckRotor stays 0, the step advances and a new full window starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset, asynchronous |
| msTick | input | 1 | 1 ms timing enable |
| startBit | input | 1 | 1 runs the motor, 0 stops and brakes |
| extMode | input | 1 | 1 selects host-stepped commutation |
| incBit | input | 1 | Rising edge advances the step in external mode |
| senseBit | input | 1 | Rising edge requests a sense step in external mode |
| stopAfterSense | input | 1 | 1 halts start-up after the sense step |
| coastBit | input | 1 | 1 disables the power outputs |
| energSel | input | 2 | Energise time code |
| stuckSel | input | 1 | Stuck-rotor window: 0 long, 1 short |
| revSel | input | 2 | Reverse-brake time code, 0 = none |
| bemfPulse | input | 1 | Back-EMF zero-crossing pulse |
| driveEn | output | 1 | Power outputs enabled |
| brakeOn | output | 1 | Normal brake applied |
| revBrakeOn | output | 1 | Reverse brake applied |
| senseOn | output | 1 | Inductive-sense step active |
| energiseOn | output | 1 | Energise step active |
| commutOn | output | 1 | Commutating (waiting, running or external) |
| spinning | output | 1 | At least one zero crossing seen since start |
| phaseStep | output | 3 | Commutation step 0..5 |
| stuckRotor | output | 1 | No back-EMF within the window |
| phaseReady | output | 1 | Sense step completed since the last start |

## Verification
The zero-crossing pulse and the close of the stuck-rotor window can fall on the same clock, and the two would drive the controller to opposite outcomes. The bench places a pulse exactly on the hundredth tick after the previous pulse, with the short window selected. It then expects stuckRotor to stay low, the step to advance and commutation to continue. It then waits exactly one further full window without pulses, confirming that the window restarted from that pulse: commutation continues on tick 99 and the brake with stuckRotor appears on tick 100.

// File: rtl/spindle_startup_pkg.sv
package spindle_startup_pkg;

  typedef enum logic [2:0] {
    ST_BRAKE,
    ST_REVBRK,
    ST_SENSE,
    ST_ENERG,
    ST_WAITZC,
    ST_RUN,
    ST_HALT,
    ST_EXT
  } spinState_t;

  typedef enum logic [1:0] {
    LD_SENSE,
    LD_ENERG,
    LD_STUCK,
    LD_REV
  } loadSel_t;

  typedef struct packed {
    logic     load;
    loadSel_t loadSel;
    logic     stepInc;
    logic     stepClr;
    logic     setStuck;
    logic     setReady;
    logic     clrFlags;
  } ctrlStrobe_t;

endpackage

// File: rtl/spindle_startup_dp.sv
module spindle_startup_dp
  import spindle_startup_pkg::*;
#(
  parameter int TIMER_W        = 10,
  parameter int SENSE_MS       = 2,
  parameter int ENERG_UNIT_MS  = 10,
  parameter int REV_UNIT_MS    = 10,
  parameter int STUCK_LONG_MS  = 400,
  parameter int STUCK_SHORT_MS = 100,
  parameter int STEPS          = 6,
  localparam int STEP_W        = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  ctrlStrobe_t       strobe,
  input  logic [1:0]        energSel,
  input  logic              stuckSel,
  input  logic [1:0]        revSel,
  input  logic              incBit,
  input  logic              senseBit,
  output logic              timerDone,
  output logic              incRise,
  output logic              senseRise,
  output logic [STEP_W-1:0] phaseStep,
  output logic              stuckRotor,
  output logic              phaseReady
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  logic [TIMER_W-1:0] tmrCnt;
  logic [TIMER_W-1:0] loadVal;
  logic               incPrev;
  logic               sensePrev;

  // Duration for the timer, chosen by the requesting state
  always_comb begin
    case (strobe.loadSel)
      LD_SENSE: loadVal = TIMER_W'(SENSE_MS);
      LD_ENERG: loadVal = TIMER_W'((int'(energSel) + 1) * ENERG_UNIT_MS);
      LD_STUCK: loadVal = stuckSel ? TIMER_W'(STUCK_SHORT_MS) : TIMER_W'(STUCK_LONG_MS);
      default: begin
        case (revSel)
          2'd1:    loadVal = TIMER_W'(REV_UNIT_MS);
          2'd2:    loadVal = TIMER_W'(REV_UNIT_MS * 2);
          2'd3:    loadVal = TIMER_W'(REV_UNIT_MS * 4);
          default: loadVal = '0;
        endcase
      end
    endcase
  end

  // Millisecond down-counter; a load wins over counting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
    end else if (strobe.load) begin
      tmrCnt <= loadVal;
    end else if (msTick && tmrCnt != '0) begin
      tmrCnt <= tmrCnt - 1'b1;
    end
  end

  assign timerDone = msTick && (tmrCnt == TIMER_W'(1));

  // Commutation step counter, wraps after the last step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseStep <= '0;
    end else if (strobe.stepClr) begin
      phaseStep <= '0;
    end else if (strobe.stepInc) begin
      phaseStep <= (phaseStep == LAST_STEP) ? '0 : phaseStep + 1'b1;
    end
  end

  // Status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stuckRotor <= 1'b0;
      phaseReady <= 1'b0;
    end else begin
      if (strobe.clrFlags)      stuckRotor <= 1'b0;
      else if (strobe.setStuck) stuckRotor <= 1'b1;
      if (strobe.clrFlags)      phaseReady <= 1'b0;
      else if (strobe.setReady) phaseReady <= 1'b1;
    end
  end

  // Edge detection of host controls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      incPrev   <= 1'b0;
      sensePrev <= 1'b0;
    end else begin
      incPrev   <= incBit;
      sensePrev <= senseBit;
    end
  end

  assign incRise   = incBit && !incPrev;
  assign senseRise = senseBit && !sensePrev;

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    phaseStep <= LAST_STEP); // R6

  AST_STUCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stuckRotor && !strobe.clrFlags) |=> stuckRotor); // R5

endmodule

// File: rtl/spindle_startup_ctrl.sv
module spindle_startup_ctrl
  import spindle_startup_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startBit,
  input  logic        extMode,
  input  logic        stopAfterSense,
  input  logic [1:0]  revSel,
  input  logic        bemfPulse,
  input  logic        timerDone,
  input  logic        incRise,
  input  logic        senseRise,
  output spinState_t  state,
  output ctrlStrobe_t strobe
);

  spinState_t nxtState;
  logic       startArmed;
  logic       startTaken;

  assign startTaken = (state == ST_BRAKE) && startBit && startArmed;

  // A start needs startBit to have been seen low since the last start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startArmed <= 1'b1;
    end else if (!startBit) begin
      startArmed <= 1'b1;
    end else if (startTaken) begin
      startArmed <= 1'b0;
    end
  end

  always_comb begin
    nxtState = state;
    strobe   = '0;
    case (state)
      ST_BRAKE: begin
        if (startTaken) begin
          strobe.clrFlags = 1'b1;
          strobe.stepClr  = 1'b1;
          if (extMode) begin
            nxtState = ST_EXT;
          end else begin
            nxtState       = ST_SENSE;
            strobe.load    = 1'b1;
            strobe.loadSel = LD_SENSE;
          end
        end
      end
      ST_REVBRK: begin
        if (timerDone) nxtState = ST_BRAKE;
      end
      default: begin
        if (!startBit) begin
          strobe.stepClr = 1'b1;
          if (revSel != 2'd0) begin
            nxtState       = ST_REVBRK;
            strobe.load    = 1'b1;
            strobe.loadSel = LD_REV;
          end else begin
            nxtState = ST_BRAKE;
          end
        end else begin
          case (state)
            ST_SENSE: begin
              if (timerDone) begin
                strobe.setReady = 1'b1;
                if (extMode) begin
                  nxtState = ST_EXT;
                end else if (stopAfterSense) begin
                  nxtState = ST_HALT;
                end else begin
                  nxtState       = ST_ENERG;
                  strobe.load    = 1'b1;
                  strobe.loadSel = LD_ENERG;
                end
              end
            end
            ST_ENERG: begin
              if (timerDone) begin
                nxtState       = ST_WAITZC;
                strobe.load    = 1'b1;
                strobe.loadSel = LD_STUCK;
              end
            end
            ST_WAITZC, ST_RUN: begin
              if (bemfPulse) begin
                nxtState       = ST_RUN;
                strobe.stepInc = 1'b1;
                strobe.load    = 1'b1;
                strobe.loadSel = LD_STUCK;
              end else if (timerDone) begin
                nxtState        = ST_BRAKE;
                strobe.setStuck = 1'b1;
                strobe.stepClr  = 1'b1;
              end
            end
            ST_EXT: begin
              if (senseRise) begin
                nxtState       = ST_SENSE;
                strobe.load    = 1'b1;
                strobe.loadSel = LD_SENSE;
              end else if (incRise) begin
                strobe.stepInc = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_BRAKE;
    else       state <= nxtState;
  end

  AST_STOP_BRAKES: assert property (@(posedge clk) disable iff (!rstN)
    (!startBit && state != ST_BRAKE && state != ST_REVBRK)
      |=> (state == ST_BRAKE || state == ST_REVBRK)); // R1

  AST_REV_TO_BRAKE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REVBRK) |=> (state == ST_REVBRK || state == ST_BRAKE)); // R7

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT && startBit) |=> (state == ST_HALT)); // R3

endmodule

// File: rtl/spindle_startup.sv
module spindle_startup
  import spindle_startup_pkg::*;
#(
  parameter int TIMER_W        = 10,
  parameter int SENSE_MS       = 2,
  parameter int ENERG_UNIT_MS  = 10,
  parameter int REV_UNIT_MS    = 10,
  parameter int STUCK_LONG_MS  = 400,
  parameter int STUCK_SHORT_MS = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       startBit,
  input  logic       extMode,
  input  logic       incBit,
  input  logic       senseBit,
  input  logic       stopAfterSense,
  input  logic       coastBit,
  input  logic [1:0] energSel,
  input  logic       stuckSel,
  input  logic [1:0] revSel,
  input  logic       bemfPulse,
  output logic       driveEn,
  output logic       brakeOn,
  output logic       revBrakeOn,
  output logic       senseOn,
  output logic       energiseOn,
  output logic       commutOn,
  output logic       spinning,
  output logic [2:0] phaseStep,
  output logic       stuckRotor,
  output logic       phaseReady
);

  spinState_t  state;
  ctrlStrobe_t strobe;
  logic        timerDone;
  logic        incRise;
  logic        senseRise;

  spindle_startup_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .startBit       (startBit),
    .extMode        (extMode),
    .stopAfterSense (stopAfterSense),
    .revSel         (revSel),
    .bemfPulse      (bemfPulse),
    .timerDone      (timerDone),
    .incRise        (incRise),
    .senseRise      (senseRise),
    .state          (state),
    .strobe         (strobe)
  );

  spindle_startup_dp #(
    .TIMER_W        (TIMER_W),
    .SENSE_MS       (SENSE_MS),
    .ENERG_UNIT_MS  (ENERG_UNIT_MS),
    .REV_UNIT_MS    (REV_UNIT_MS),
    .STUCK_LONG_MS  (STUCK_LONG_MS),
    .STUCK_SHORT_MS (STUCK_SHORT_MS),
    .STEPS          (6)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .msTick     (msTick),
    .strobe     (strobe),
    .energSel   (energSel),
    .stuckSel   (stuckSel),
    .revSel     (revSel),
    .incBit     (incBit),
    .senseBit   (senseBit),
    .timerDone  (timerDone),
    .incRise    (incRise),
    .senseRise  (senseRise),
    .phaseStep  (phaseStep),
    .stuckRotor (stuckRotor),
    .phaseReady (phaseReady)
  );

  assign driveEn    = rstN && !coastBit;
  assign brakeOn    = (state == ST_BRAKE);
  assign revBrakeOn = (state == ST_REVBRK);
  assign senseOn    = (state == ST_SENSE);
  assign energiseOn = (state == ST_ENERG);
  assign commutOn   = (state == ST_WAITZC) || (state == ST_RUN) || (state == ST_EXT);
  assign spinning   = (state == ST_RUN);

  AST_STUCK_BRAKES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stuckRotor) |-> brakeOn); // R5

  AST_SPIN_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spinning) |-> $past(bemfPulse)); // R6

endmodule

// File: tb/tb_spindle_startup.sv
module tb_spindle_startup;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       msTick = 1'b1;
  logic       startBit = 1'b0;
  logic       extMode = 1'b0;
  logic       incBit = 1'b0;
  logic       senseBit = 1'b0;
  logic       stopAfterSense = 1'b0;
  logic       coastBit = 1'b0;
  logic [1:0] energSel = 2'd0;
  logic       stuckSel = 1'b0;
  logic [1:0] revSel = 2'd0;
  logic       bemfPulse = 1'b0;
  logic       driveEn, brakeOn, revBrakeOn, senseOn, energiseOn, commutOn, spinning;
  logic [2:0] phaseStep;
  logic       stuckRotor, phaseReady;

  int checks = 0;
  int errors = 0;

  spindle_startup dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .startBit(startBit), .extMode(extMode),
    .incBit(incBit), .senseBit(senseBit), .stopAfterSense(stopAfterSense),
    .coastBit(coastBit), .energSel(energSel), .stuckSel(stuckSel), .revSel(revSel),
    .bemfPulse(bemfPulse), .driveEn(driveEn), .brakeOn(brakeOn), .revBrakeOn(revBrakeOn),
    .senseOn(senseOn), .energiseOn(energiseOn), .commutOn(commutOn), .spinning(spinning),
    .phaseStep(phaseStep), .stuckRotor(stuckRotor), .phaseReady(phaseReady)
  );

  always #5 clk = ~clk;

  // energSel, stuckSel, revSel, expected energise, stuck window, reverse brake
  localparam int VEC [4][6] = '{
    '{0, 0, 1, 10, 400, 10},
    '{1, 1, 2, 20, 100, 20},
    '{2, 0, 3, 30, 400, 40},
    '{3, 1, 0, 40, 100, 0}
  };
  localparam int SENSE_T = 2;

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count cycles a chosen output stays high: 0 sense,1 energise,2 commut,3 revbrake
  task automatic measure(input int which, output int n);
    n = 0;
    while (n < 1000) begin
      logic s;
      case (which)
        0: s = senseOn;
        1: s = energiseOn;
        2: s = commutOn;
        default: s = revBrakeOn;
      endcase
      if (!s) break;
      n++;
      cyc(1);
    end
  endtask

  task automatic restart();
    startBit = 1'b0;
    cyc(1);
    startBit = 1'b1;
    cyc(1);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // R8 / R1: reset state
    #3;
    chk("R8 driveEn in reset", int'(driveEn), 0);
    cyc(2);
    rstN = 1'b1;
    cyc(1);
    chk("R1 brake after reset", int'(brakeOn), 1);
    chk("R1 step after reset", int'(phaseStep), 0);
    chk("R1 stuck after reset", int'(stuckRotor), 0);
    chk("R1 ready after reset", int'(phaseReady), 0);
    chk("R8 driveEn out of reset", int'(driveEn), 1);

    // Table walk: R2 timing, R5 window, R7 reverse brake
    for (int i = 0; i < 4; i++) begin
      energSel = 2'(VEC[i][0]);
      stuckSel = VEC[i][1][0];
      revSel   = 2'(VEC[i][2]);
      restart();
      chk("R2 sense entered", int'(senseOn), 1);
      measure(0, n);
      chk("R2 sense length", n, SENSE_T);
      measure(1, n);
      chk("R2 energise length", n, VEC[i][3]);
      measure(2, n);
      chk("R5 stuck window", n, VEC[i][4]);
      chk("R5 stuck flag", int'(stuckRotor), 1);
      chk("R5 brake no reverse", int'(brakeOn), 1);
      chk("R1 step cleared", int'(phaseStep), 0);
      restart();
      chk("R5 stuck cleared on start", int'(stuckRotor), 0);
      startBit = 1'b0;
      cyc(1);
      measure(3, n);
      chk("R7 reverse brake length", n, VEC[i][5]);
      chk("R7 brake after reverse", int'(brakeOn), 1);
    end

    // R7: start raised during reverse brake is ignored until brake reached
    revSel = 2'd1;
    restart();
    startBit = 1'b0;
    cyc(1);
    startBit = 1'b1;
    measure(3, n);
    chk("R7 reverse completes despite start", n, 10);
    chk("R7 brake one cycle", int'(brakeOn), 1);
    cyc(1);
    chk("R7 deferred start", int'(senseOn), 1);
    revSel = 2'd0;
    startBit = 1'b0;
    cyc(1);
    chk("R1 stop from sense", int'(brakeOn), 1);

    // R3: halt after sense
    stopAfterSense = 1'b1;
    startBit = 1'b1;
    cyc(1);
    measure(0, n);
    chk("R3 sense length", n, SENSE_T);
    chk("R3 ready", int'(phaseReady), 1);
    chk("R3 no energise", int'(energiseOn), 0);
    cyc(50);
    chk("R3 halt holds", int'(energiseOn | commutOn | brakeOn | senseOn), 0);
    startBit = 1'b0;
    cyc(1);
    chk("R3 leaves on stop", int'(brakeOn), 1);
    stopAfterSense = 1'b0;

    // R6 / R8 / R9: running with pulses
    energSel = 2'd0;
    stuckSel = 1'b1;
    startBit = 1'b1;
    cyc(1);
    measure(0, n);
    measure(1, n);
    chk("R6 waiting", int'(commutOn), 1);
    chk("R6 not spinning yet", int'(spinning), 0);
    for (int k = 1; k <= 7; k++) begin
      bemfPulse = 1'b1;
      cyc(1);
      bemfPulse = 1'b0;
      chk("R6 step advance", int'(phaseStep), k % 6);
      chk("R6 spinning", int'(spinning), 1);
      cyc(90);
      chk("R6 window restarted", int'(stuckRotor), 0);
    end
    coastBit = 1'b1;
    #1;
    chk("R8 coast disables", int'(driveEn), 0);
    chk("R8 state kept", int'(commutOn), 1);
    coastBit = 1'b0;
    #1;
    chk("R8 coast released", int'(driveEn), 1);
    bemfPulse = 1'b1;
    cyc(1);
    bemfPulse = 1'b0;
    chk("R6 step before coincidence", int'(phaseStep), 2);
    cyc(99);
    bemfPulse = 1'b1;
    cyc(1);
    bemfPulse = 1'b0;
    chk("R9 no stuck on coincidence", int'(stuckRotor), 0);
    chk("R9 still commutating", int'(commutOn), 1);
    chk("R9 step advanced", int'(phaseStep), 3);
    cyc(99);
    chk("R9 new window running", int'(commutOn), 1);
    cyc(1);
    chk("R9 window expired", int'(stuckRotor), 1);
    chk("R5 brake on expiry", int'(brakeOn), 1);

    // R4: external mode
    extMode = 1'b1;
    restart();
    chk("R4 external entered", int'(commutOn), 1);
    chk("R4 no sense", int'(senseOn), 0);
    chk("R4 step zero", int'(phaseStep), 0);
    incBit = 1'b1;
    cyc(1);
    chk("R4 inc rise", int'(phaseStep), 1);
    cyc(3);
    chk("R4 level no advance", int'(phaseStep), 1);
    incBit = 1'b0;
    cyc(1);
    bemfPulse = 1'b1;
    cyc(1);
    bemfPulse = 1'b0;
    chk("R4 bemf ignored", int'(phaseStep), 1);
    incBit = 1'b1;
    senseBit = 1'b1;
    cyc(1);
    chk("R4 sense wins", int'(senseOn), 1);
    chk("R4 step held", int'(phaseStep), 1);
    measure(0, n);
    chk("R4 sense length", n, SENSE_T);
    chk("R4 back to external", int'(commutOn), 1);
    chk("R4 ready", int'(phaseReady), 1);
    incBit = 1'b0;
    senseBit = 1'b0;
    cyc(1);
    for (int j = 0; j < 6; j++) begin
      incBit = 1'b1;
      cyc(1);
      incBit = 1'b0;
      cyc(1);
      chk("R4 external stepping", int'(phaseStep), (2 + j) % 6);
    end
    startBit = 1'b0;
    cyc(1);
    chk("R1 stop from external", int'(brakeOn), 1);
    chk("R1 step cleared on stop", int'(phaseStep), 0);

    // R8: reset mid-operation
    rstN = 1'b0;
    #1;
    chk("R8 reset disables", int'(driveEn), 0);
    chk("R1 brake during reset", int'(brakeOn), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule